// File: doc/BRIEF.md
# Display Line Fetch Burst Sequencer

This block produces the read requests a display controller needs to pull one scan line of pixel data out of shared memory. A one-cycle start strobe captures a line start byte address, a line length counted in 32-bit words, a nominal burst size and the data bus width. The sequencer then issues read bursts toward a memory arbiter, one after another, until the whole line has been requested and its data returned. It then raises a one-cycle completion pulse and waits for the next strobe.

Each burst is a request/grant handshake followed by a data phase, in which the block counts accepted beats. A new request is raised only after the last beat of the current burst. The nominal size is given in words. On a 16-bit bus it is doubled into beats, so the burst covers the same number of bytes on either width. When fewer words remain than the nominal size, the final burst is cut down to exactly what is left. A strobe that arrives while a line is still being fetched is dropped and reported.

Top module: `line_burst_seq`

## Requirements
- R1: While reset is active and after its release, `req_valid`, `line_done` and `overrun` are 0 until a start strobe is accepted.
- R2: A start strobe accepted while idle with a nonzero `line_words` raises `req_valid` in the next cycle, with `req_addr` equal to `line_addr`. While `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold their values.
- R3: The nominal burst in words is `burst_cfg` clamped to the range 4 to 32. `req_len` gives beats: words on a 32-bit bus (`bus_is16`=0) and twice the words on a 16-bit bus (`bus_is16`=1). The range is therefore 4 to 32 beats on a 32-bit bus and 8 to 64 beats on a 16-bit bus.
- R4: When the remaining words are fewer than the nominal burst, the request covers exactly the remainder. Over a line, the `req_len` values granted add up to `line_words` words in beats.
- R5: Each following request address is the previous address plus 4 times the words of the previous burst.
- R6: After a grant, `req_valid` stays low until the granted burst's last beat has been accepted on `beat_valid`. Outside a data phase, `beat_valid` is ignored.
- R7: `line_done` pulses for one cycle right after the edge that accepts the final beat. For a zero-length line it pulses right after the strobe, and no request is made. After the pulse the block stays idle until the next strobe.
- R8: A strobe taken while a line is in progress has no effect on the requests. It produces a one-cycle `overrun` pulse in the next cycle.
- R9: Address, length, burst size and bus width are captured at the accepted strobe. Later changes on those inputs do not affect the line in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle line start strobe |
| line_addr | input | AW | Line start byte address |
| line_words | input | LW | Line length in 32-bit words |
| burst_cfg | input | 6 | Nominal burst size in words |
| bus_is16 | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| req_valid | output | 1 | Burst read request |
| req_addr | output | AW | Burst start byte address |
| req_len | output | 7 | Burst length in beats |
| req_ready | input | 1 | Arbiter grant for the pending request |
| beat_valid | input | 1 | One data beat accepted |
| line_done | output | 1 | Line completion pulse |
| overrun | output | 1 | Pulse for a strobe dropped while busy |

## Verification
The hardest situation to reach from the ports is a strobe that lands during an active line while the line's configuration inputs are changing. To check that it is ignored, the bench has to tell a dropped strobe apart from a restarted line. In noisy runs the bench fires stray strobes only while a request is waiting for a grant, and it randomises `line_addr`, `line_words`, `burst_cfg` and `bus_is16` on every cycle. A cycle-by-cycle reference model and a per-line tally of granted beats then show that the line went on unchanged. Back-to-back lines are started in the very cycle that `line_done` is high, to exercise restart from the completion cycle.

// File: rtl/line_burst_seq.sv
module line_burst_seq #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [AW-1:0] line_addr,
  input  logic [LW-1:0] line_words,
  input  logic [5:0]    burst_cfg,
  input  logic          bus_is16,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [6:0]    req_len,
  input  logic          req_ready,
  input  logic          beat_valid,
  output logic          line_done,
  output logic          overrun
);

  localparam logic [5:0] MIN_W = 6'd4;
  localparam logic [5:0] MAX_W = 6'd32;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;

  st_t           st;
  logic [LW-1:0] rem;
  logic [5:0]    bw;
  logic          b16;
  logic [6:0]    cnt;
  logic [5:0]    nw;
  logic [5:0]    cfg_cl;

  assign cfg_cl    = (burst_cfg < MIN_W) ? MIN_W : (burst_cfg > MAX_W) ? MAX_W : burst_cfg;
  assign nw        = (rem < LW'(bw)) ? rem[5:0] : bw;
  assign req_valid = (st == S_REQ);
  assign req_len   = b16 ? {nw, 1'b0} : {1'b0, nw};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      bw        <= MIN_W;
      b16       <= 1'b0;
      cnt       <= '0;
      req_addr  <= '0;
      line_done <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      line_done <= 1'b0;
      overrun   <= line_start && (st != S_IDLE);
      case (st)
        S_IDLE: if (line_start) begin
          req_addr <= line_addr;
          rem      <= line_words;
          bw       <= cfg_cl;
          b16      <= bus_is16;
          if (line_words == '0) line_done <= 1'b1;
          else                  st        <= S_REQ;
        end
        S_REQ: if (req_ready) begin
          cnt      <= req_len;
          req_addr <= req_addr + AW'({nw, 2'b00});
          rem      <= rem - LW'(nw);
          st       <= S_DATA;
        end
        default: if (beat_valid) begin
          cnt <= cnt - 7'd1;
          if (cnt == 7'd1) begin
            if (rem == '0) begin
              line_done <= 1'b1;
              st        <= S_IDLE;
            end else begin
              st <= S_REQ;
            end
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != 7'd0) && (req_len <= (b16 ? 7'd64 : 7'd32))); // R3
  AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !req_valid); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(line_start)); // R8

endmodule

// File: tb/test_line_burst_seq.sv
module test_line_burst_seq;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_start = 1'b0;
  logic [AW-1:0] line_addr = '0;
  logic [LW-1:0] line_words = '0;
  logic [5:0]    burst_cfg = 6'd8;
  logic          bus_is16 = 1'b0;
  logic          req_ready = 1'b0;
  logic          beat_valid = 1'b0;
  logic          req_valid, line_done, overrun;
  logic [AW-1:0] req_addr;
  logic [6:0]    req_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_phase = 0;
  longint m_addr = 0;
  int m_rem = 0, m_bw = 4, m_b16 = 0, m_cnt = 0;
  bit m_done = 0, m_ovr = 0;
  int port_tot = 0;

  line_burst_seq #(.AW(AW), .LW(LW)) i_line_burst_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_addr(line_addr),
    .line_words(line_words), .burst_cfg(burst_cfg), .bus_is16(bus_is16),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_ready(req_ready), .beat_valid(beat_valid),
    .line_done(line_done), .overrun(overrun)
  );

  always #5 clk = ~clk;

  function automatic int clampw(int c);
    return (c < 4) ? 4 : (c > 32) ? 32 : c;
  endfunction

  function automatic int cur_words();
    return (m_rem < m_bw) ? m_rem : m_bw;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst_n && req_valid && req_ready) port_tot += int'(req_len);
    m_done = 0;
    m_ovr  = 0;
    if (!rst_n) begin
      m_phase = 0;
    end else begin
      if (line_start && m_phase != 0) m_ovr = 1;
      if (m_phase == 0) begin
        if (line_start) begin
          m_addr = longint'(line_addr);
          m_rem  = int'(line_words);
          m_bw   = clampw(int'(burst_cfg));
          m_b16  = int'(bus_is16);
          if (m_rem == 0) m_done = 1;
          else m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (req_ready) begin
          int n;
          n = cur_words();
          m_cnt  = m_b16 ? 2 * n : n;
          m_addr = (m_addr + 4 * n) & 64'hFFFF_FFFF;
          m_rem  = m_rem - n;
          m_phase = 2;
        end
      end else if (beat_valid) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_rem == 0) begin
            m_done  = 1;
            m_phase = 0;
          end else m_phase = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  task automatic compare();
    int w;
    w = cur_words();
    chk(req_valid == (m_phase == 1), "R2/R6 req_valid", req_valid, m_phase == 1);
    if (m_phase == 1) begin
      chk(longint'(req_addr) == m_addr, "R5 req_addr", req_addr, m_addr);
      chk(int'(req_len) == (m_b16 ? 2 * w : w), "R3/R4 req_len", req_len, m_b16 ? 2 * w : w);
    end
    chk(line_done == m_done, "R7 line_done", line_done, m_done);
    chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
  endtask

  task automatic summary_exit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_line(input logic [AW-1:0] a, input int words, input int cfg,
                          input bit b16, input bit noise);
    int exp_beats;
    int guard = 0;
    exp_beats = b16 ? 2 * words : words;
    port_tot = 0;
    line_start = 1'b1;
    line_addr  = a;
    line_words = LW'(words);
    burst_cfg  = 6'(cfg);
    bus_is16   = b16;
    forever begin
      @(negedge clk);
      compare();
      if (m_phase == 0) break;
      guard++;
      if (guard > 20000 || cycles > 150000) begin
        chk(0, "R7 watchdog", guard, 0);
        summary_exit();
      end
      req_ready  = ($urandom_range(0, 2) != 0);
      beat_valid = ($urandom_range(0, 3) != 0);
      line_start = 1'b0;
      if (noise) begin
        // R9: configuration inputs wander mid-line; stray strobes for R8
        line_addr  = $urandom;
        line_words = LW'($urandom_range(0, 200));
        burst_cfg  = 6'($urandom_range(0, 63));
        bus_is16   = 1'($urandom_range(0, 1));
        if (m_phase == 1 && $urandom_range(0, 5) == 0) line_start = 1'b1;
      end
    end
    line_start = 1'b0;
    req_ready  = 1'b0;
    beat_valid = 1'b0;
    chk(port_tot == exp_beats, "R4/R9 total beats per line", port_tot, exp_beats);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(!req_valid && !line_done && !overrun, "R1 reset outputs", {req_valid, line_done, overrun}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    chk(!req_valid, "R1 idle after reset", req_valid, 0);
    run_line(32'h0000_1000, 70, 32, 1'b0, 1'b0);
    run_line(32'h0000_2000, 70, 32, 1'b1, 1'b0);
    run_line(32'h0000_3000, 10, 2, 1'b0, 1'b0);
    run_line(32'h0000_4000, 40, 60, 1'b1, 1'b0);
    run_line(32'h0000_4800, 0, 16, 1'b0, 1'b0);
    run_line(32'h0000_5000, 64, 16, 1'b0, 1'b0);
    run_line(32'h0000_6000, 3, 32, 1'b1, 1'b0);
    run_line(32'h0000_7000, 100, 8, 1'b1, 1'b1);
    run_line(32'hFFFF_FF00, 90, 12, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++)
      run_line($urandom, $urandom_range(0, 150), $urandom_range(0, 63),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    repeat (4) begin
      @(negedge clk);
      compare();
      chk(!req_valid, "R7 stays idle", req_valid, 0);
    end
    summary_exit();
  end
endmodule